// File: doc/BRIEF.md
# Numeric Status Word with Error Summary

This block keeps the status word of a floating-point stack unit. It holds a 3-bit stack-top pointer, four condition-code bits, a stack-fault flag and six sticky exception flags. A 6-bit mask field, taken from the unit's control word, is combined with the flags to form an error summary bit. The summary bit is also mirrored into the busy position of the word and drives an error output toward the host.

The surrounding datapath sends the block one-cycle pulses:

- set individual exceptions;
- report a stack fault with its direction;
- clear all exceptions;
- write the condition codes;
- write the stack-top pointer;
- load the whole word at once, as when a saved environment is restored.

The summary and busy bits are never stored. They are always rebuilt from the current flags and masks. As a result, a restored word with an unmasked flag raises the error output in the cycle right after the load, and a mask change acts without latency.

Top module: `fpu_stat_word`

## Requirements
- R1: While reset is low, and after its release until the first update, the status word is 0x0000 and `err_o` is 0.
- R2: Word layout: bit 15 busy mirror, 14 C3, 13..11 stack top, 10 C2, 9 C1, 8 C0, 7 error summary, 6 stack-fault flag, 5..0 exception flags. On `cc_i`, bit 3 is C3 and bit 0 is C0.
- R3: Each 1 bit on `exc_set_i` sets the matching exception flag on the next clock edge. Flags stay set until a clear or a load.
- R4: `exc_clr_i` zeroes all six flags and the stack-fault flag on the next edge. Exception pulses and stack-fault flag setting in the same cycle have no effect.
- R5: The error summary is 1 exactly when some flag is 1 and its `mask_i` bit (1 = masked) is 0. `err_o` equals the summary, and a mask change takes effect in the same cycle.
- R6: Bit 15 of the word always equals bit 7.
- R7: `stk_fault_i` sets flag 0 and the stack-fault flag, and writes `stk_over_i` (1 = overflow, 0 = underflow) into C1. This C1 value takes priority over `cc_i` in the same cycle.
- R8: `load_i` copies stack top, condition codes, stack-fault flag and exception flags from `load_word_i` at their R2 positions. Bits 15 and 7 of `load_word_i` are ignored. The load overrides every other update in that cycle.
- R9: `cc_we_i` writes `cc_i` into C3..C0, and `top_we_i` writes `top_i` into the stack-top field, on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_set_i | input | 6 | Exception set pulses, one per flag |
| exc_clr_i | input | 1 | Clear all exceptions and stack-fault flag |
| stk_fault_i | input | 1 | Stack fault pulse |
| stk_over_i | input | 1 | Fault direction, 1 = overflow |
| cc_we_i | input | 1 | Condition-code write enable |
| cc_i | input | 4 | New condition codes C3..C0 |
| top_we_i | input | 1 | Stack-top write enable |
| top_i | input | 3 | New stack-top value |
| load_i | input | 1 | Full word load strobe |
| load_word_i | input | 16 | Word to load |
| mask_i | input | 6 | Exception masks, 1 = masked |
| status_o | output | 16 | Assembled status word |
| err_o | output | 1 | Error output, equals summary bit |

## Verification
The hardest case to reach is a loaded word whose stored summary and busy bits disagree with its flags. In that case the block must discard the loaded bits and rebuild them from the flags.

The stimulus covers both directions:
- It loads 0x8080, which has both summary bits set but no flags, and expects a zero word.
- It loads a word with one flag masked and expects a quiet output, then unmasks that flag in a cycle with no other activity and expects `err_o` to rise at once.

Same-cycle collisions are also driven: a load against a clear, set pulses and a top write; a clear against set pulses; and a fault against a condition-code write.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
   localparam int FSW_W   = 16;
   localparam int EXC_N   = 6;
   localparam int TOP_N   = 3;
   localparam int CC_N    = 4;
   // bit positions inside the word; neighbours decode these
   localparam int POS_B   = 15;
   localparam int POS_C3  = 14;
   localparam int POS_TOP = 11;
   localparam int POS_C2  = 10;
   localparam int POS_C1  = 9;
   localparam int POS_C0  = 8;
   localparam int POS_ES  = 7;
   localparam int POS_SF  = 6;
   localparam int CC_C1   = 1;   // index of C1 inside the cc vector
endpackage

// File: rtl/fsw_exc_flags.sv
module fsw_exc_flags #(
   parameter int N = fsw_pkg::EXC_N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [N-1:0] load_flags_i,
   input  logic         load_sf_i,
   input  logic         clr_i,
   input  logic [N-1:0] set_i,
   input  logic         fault_i,
   output logic [N-1:0] flags_o,
   output logic         sf_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("fsw_exc_flags: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] set_all;
   assign set_all = set_i | {{(N-1){1'b0}}, fault_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_o <= '0;
         sf_o    <= 1'b0;
      end else if (load_i) begin
         flags_o <= load_flags_i;
         sf_o    <= load_sf_i;
      end else if (clr_i) begin
         flags_o <= '0;
         sf_o    <= 1'b0;
      end else begin
         flags_o <= flags_o | set_all;
         sf_o    <= sf_o | fault_i;
      end
   end

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !clr_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
   assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !clr_i && set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !load_i) |=> (flags_o == '0 && !sf_o));
   assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (flags_o == $past(load_flags_i) && sf_o == $past(load_sf_i)));
endmodule

// File: rtl/fsw_fields.sv
module fsw_fields #(
   parameter int TW = fsw_pkg::TOP_N,
   parameter int CW = fsw_pkg::CC_N
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_top_i,
   input  logic [CW-1:0] load_cc_i,
   input  logic          top_we_i,
   input  logic [TW-1:0] top_i,
   input  logic          cc_we_i,
   input  logic [CW-1:0] cc_i,
   input  logic          fault_i,
   input  logic          over_i,
   output logic [TW-1:0] top_o,
   output logic [CW-1:0] cc_o
);
   localparam int C1 = fsw_pkg::CC_C1;

   generate
      if (CW <= C1) begin : g_bad_cw
         $error("fsw_fields: cc vector too narrow for C1");
      end
   endgenerate

   logic [CW-1:0] cc_nxt;
   always_comb begin
      cc_nxt = cc_we_i ? cc_i : cc_o;
      if (fault_i) cc_nxt[C1] = over_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_o <= '0;
         cc_o  <= '0;
      end else if (load_i) begin
         top_o <= load_top_i;
         cc_o  <= load_cc_i;
      end else begin
         if (top_we_i) top_o <= top_i;
         cc_o <= cc_nxt;
      end
   end

   assert_fault_c1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_i && !load_i) |=> (cc_o[C1] == $past(over_i)));
   assert_top_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (top_we_i && !load_i) |=> (top_o == $past(top_i)));
endmodule

// File: rtl/fsw_summary.sv
module fsw_summary #(
   parameter int N = fsw_pkg::EXC_N
) (
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] mask_i,
   output logic         es_o
);
   logic [N-1:0] live;
   generate
      for (genvar i = 0; i < N; i++) begin : g_live
         assign live[i] = flags_i[i] & ~mask_i[i];
      end
   endgenerate
   assign es_o = |live;
endmodule

// File: rtl/fpu_stat_word.sv
module fpu_stat_word
   import fsw_pkg::*;
#(
   parameter int EXC_W  = EXC_N,
   parameter int TOP_W  = TOP_N,
   parameter int CC_W   = CC_N,
   parameter int WORD_W = FSW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EXC_W-1:0]  exc_set_i,
   input  logic              exc_clr_i,
   input  logic              stk_fault_i,
   input  logic              stk_over_i,
   input  logic              cc_we_i,
   input  logic [CC_W-1:0]   cc_i,
   input  logic              top_we_i,
   input  logic [TOP_W-1:0]  top_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_word_i,
   input  logic [EXC_W-1:0]  mask_i,
   output logic [WORD_W-1:0] status_o,
   output logic              err_o
);
   generate
      if (EXC_W != EXC_N || TOP_W != TOP_N || CC_W != CC_N || WORD_W != FSW_W) begin : g_bad_layout
         $error("fpu_stat_word: field widths must match the fixed word layout");
      end
   endgenerate

   logic [EXC_W-1:0] flags;
   logic             sf;
   logic [TOP_W-1:0] top;
   logic [CC_W-1:0]  cc;
   logic             es;

   logic [CC_W-1:0]  ld_cc;
   assign ld_cc = {load_word_i[POS_C3], load_word_i[POS_C2],
                   load_word_i[POS_C1], load_word_i[POS_C0]};

   logic unused_ld_bits;
   assign unused_ld_bits = load_word_i[POS_B] ^ load_word_i[POS_ES];

   fsw_exc_flags #(.N(EXC_W)) u_exc (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .load_flags_i (load_word_i[EXC_W-1:0]),
      .load_sf_i    (load_word_i[POS_SF]),
      .clr_i        (exc_clr_i),
      .set_i        (exc_set_i),
      .fault_i      (stk_fault_i),
      .flags_o      (flags),
      .sf_o         (sf)
   );

   fsw_fields #(.TW(TOP_W), .CW(CC_W)) u_fields (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_top_i (load_word_i[POS_TOP+TOP_W-1:POS_TOP]),
      .load_cc_i  (ld_cc),
      .top_we_i   (top_we_i),
      .top_i      (top_i),
      .cc_we_i    (cc_we_i),
      .cc_i       (cc_i),
      .fault_i    (stk_fault_i),
      .over_i     (stk_over_i),
      .top_o      (top),
      .cc_o       (cc)
   );

   fsw_summary #(.N(EXC_W)) u_sum (
      .flags_i (flags),
      .mask_i  (mask_i),
      .es_o    (es)
   );

   always_comb begin
      status_o              = '0;
      status_o[EXC_W-1:0]   = flags;
      status_o[POS_SF]      = sf;
      status_o[POS_ES]      = es;
      status_o[POS_C0]      = cc[0];
      status_o[POS_C1]      = cc[1];
      status_o[POS_C2]      = cc[2];
      status_o[POS_TOP+TOP_W-1:POS_TOP] = top;
      status_o[POS_C3]      = cc[3];
      status_o[POS_B]       = es;
   end
   assign err_o = es;

   assert_fault_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_fault_i && !load_i && !exc_clr_i) |=> (status_o[POS_SF] && status_o[0]));
   assert_err_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && $stable(mask_i) && ((load_word_i[EXC_W-1:0] & ~mask_i) != '0)) |=> err_o);
endmodule

// File: tb/tb_fpu_stat_word.sv
`timescale 1ns/1ps
module tb_fpu_stat_word;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  exc_set = '0;
   logic        exc_clr = 1'b0;
   logic        flt = 1'b0;
   logic        over = 1'b0;
   logic        cc_we = 1'b0;
   logic [3:0]  cc_v = '0;
   logic        top_we = 1'b0;
   logic [2:0]  top_v = '0;
   logic        ld = 1'b0;
   logic [15:0] ld_w = '0;
   logic [5:0]  msk = '0;
   logic [15:0] status;
   logic        err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   fpu_stat_word dut (
      .clk(clk), .rst_n(rst_n), .exc_set_i(exc_set), .exc_clr_i(exc_clr),
      .stk_fault_i(flt), .stk_over_i(over), .cc_we_i(cc_we), .cc_i(cc_v),
      .top_we_i(top_we), .top_i(top_v), .load_i(ld), .load_word_i(ld_w),
      .mask_i(msk), .status_o(status), .err_o(err)
   );

   // reference state built from the requirements
   logic [5:0] m_flags = '0;
   logic       m_sf = 1'b0;
   logic [2:0] m_top = '0;
   logic [3:0] m_cc = '0;

   logic [15:0] q_word[$];
   logic        q_err[$];
   string       q_tag[$];

   function automatic logic [15:0] exp_word(logic [5:0] m);
      logic es;
      es = |(m_flags & ~m);
      return {es, m_cc[3], m_top, m_cc[2], m_cc[1], m_cc[0], es, m_sf, m_flags};
   endfunction

   task automatic check(string tag, logic [15:0] aw, logic [15:0] ew, logic ae, logic ee);
      checks++;
      if (aw !== ew || ae !== ee) begin
         fails++;
         $display("FAIL %s: word=%h err=%b expected word=%h err=%b", tag, aw, ae, ew, ee);
      end
   endtask

   // driver: apply one cycle of stimulus at the falling edge, queue expectation
   task automatic drive(logic [5:0] s, logic c, logic f, logic o, logic cwe,
                        logic [3:0] cv, logic twe, logic [2:0] tv,
                        logic l, logic [15:0] lw, logic [5:0] m, string tag);
      @(negedge clk);
      exc_set = s; exc_clr = c; flt = f; over = o; cc_we = cwe; cc_v = cv;
      top_we = twe; top_v = tv; ld = l; ld_w = lw; msk = m;
      if (l) begin
         m_flags = lw[5:0]; m_sf = lw[6]; m_top = lw[13:11];
         m_cc = {lw[14], lw[10], lw[9], lw[8]};
      end else begin
         if (c) begin
            m_flags = '0; m_sf = 1'b0;
         end else begin
            m_flags = m_flags | s | {5'b0, f};
            m_sf = m_sf | f;
         end
         if (cwe) m_cc = cv;
         if (f) m_cc[1] = o;
         if (twe) m_top = tv;
      end
      q_word.push_back(exp_word(m));
      q_err.push_back(|(m_flags & ~m));
      q_tag.push_back(tag);
   endtask

   task automatic idle(logic [5:0] m, string tag);
      drive('0, 0, 0, 0, 0, '0, 0, '0, 0, '0, m, tag);
   endtask

   // monitor: compare after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_word.size() != 0) begin
            logic [15:0] w;
            logic e;
            string t;
            w = q_word.pop_front();
            e = q_err.pop_front();
            t = q_tag.pop_front();
            check(t, status, w, err, e);
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: word=%h err=%b expected word=done err=done", status, err);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 during reset", status, 16'h0000, err, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check("R1 after release", status, 16'h0000, err, 1'b0);

      drive(6'b000100, 0, 0, 0, 0, '0, 0, '0, 0, '0, 6'h00, "R3 R5 set flag2 unmasked");
      idle(6'h00, "R3 flag stays sticky");
      idle(6'b000100, "R5 masking flag2 drops error");
      drive(6'b010000, 1, 0, 0, 0, '0, 0, '0, 0, '0, 6'h00, "R4 clear beats set");
      drive(6'b100010, 0, 0, 0, 0, '0, 0, '0, 0, '0, 6'h3f, "R5 all masked");
      idle(6'b011111, "R5 flag5 unmasked");
      drive('0, 0, 0, 0, 1, 4'b1010, 1, 3'd5, 0, '0, 6'h3f, "R9 R2 write top and cc");
      drive('0, 0, 1, 1, 1, 4'b0000, 0, '0, 0, '0, 6'h3f, "R7 overflow beats cc write");
      drive('0, 0, 1, 0, 0, '0, 0, '0, 0, '0, 6'h3e, "R7 underflow");
      drive('0, 1, 1, 1, 0, '0, 0, '0, 0, '0, 6'h00, "R4 clear beats fault flags");
      drive('0, 0, 0, 0, 0, '0, 0, '0, 1, 16'hFFFF, 6'h00, "R8 load all ones");
      drive('0, 0, 0, 0, 0, '0, 0, '0, 1, 16'h8080, 6'h00, "R8 loaded B and ES ignored");
      drive('0, 0, 0, 0, 0, '0, 0, '0, 1, 16'h2B01, 6'h01, "R8 load masked flag");
      idle(6'h00, "R5 R6 unmask after load");
      drive(6'h3f, 1, 1, 1, 1, 4'hF, 1, 3'd2, 1, 16'h4C42, 6'h00, "R8 load beats other updates");
      idle(6'h00, "R6 busy mirrors summary");
      repeat (3) @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule